// File: doc/BRIEF.md
# Debounced Push-Button Press Counter

This block counts presses of a mechanical push button and presents the running total on a small binary count output. It runs entirely from one fast system clock, nominally 100 MHz. The raw button input reads high while the button is held and low at rest. Mechanical contacts bounce, so a single physical press can arrive as a burst of transitions.

The raw input first passes through a two-stage synchronizer. A free-running divider then produces a single-cycle sample enable every `TICK_DIV` system cycles. The default of 50,000,000 gives a human-scale rate; a bench can use a value as small as 50. A new debounced level is accepted only when two consecutive samples agree and differ from the current level. Accepting a high level emits a one-cycle press pulse. Accepting a low level emits a one-cycle release pulse on a separate output. Only the press pulse advances the counter.

The whole design stays in one clock domain: the slow rate is an enable, not a derived clock.

Top module: `btn_press_counter`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it falls, `count_o` is 0 and both pulse outputs are low. The debounced level returns to released during reset. If the button was held before reset and is low afterwards, no release pulse follows.
- R2: Holding the button high for longer than three sample periods produces exactly one press pulse. That pulse is one system cycle wide, and no release pulse appears during the hold.
- R3: Returning the button low for longer than three sample periods produces exactly one release pulse, one system cycle wide, and leaves `count_o` unchanged.
- R4: A burst of input toggling shorter than one sample period that settles high yields exactly one press pulse.
- R5: A glitch shorter than one sample period yields no pulse. This holds for a high glitch while released (no press pulse) and for a low glitch while pressed (no release pulse). `count_o` does not change in either case.
- R6: `count_o` rises by exactly one on the clock edge where `press_o` is high and holds otherwise. Bit 0 of `count_o` is the least significant bit.
- R7: `count_o` is an unsigned `CNT_W`-bit count (4 bits by default) that wraps from 15 to 0.
- R8: After the input becomes steadily high, the press pulse appears no earlier than `TICK_DIV+1` and no later than `2*TICK_DIV+4` system cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_i | input | 1 | Raw button level, high while pressed |
| press_o | output | 1 | One-cycle pulse when a press is accepted |
| release_o | output | 1 | One-cycle pulse when a release is accepted |
| count_o | output | CNT_W | Number of accepted presses, modulo 2^CNT_W |

## Verification
The press or release pulse arrives one cycle after the sample enable that confirms the second agreeing sample. Counting the synchronizer, this falls between `TICK_DIV+1` and `2*TICK_DIV+4` cycles after the input settles. `count_o` moves one cycle after the pulse.

The bench drives inputs on falling edges and tallies pulses on falling edges. Each scenario holds the input steady for four sample periods before it compares pulse tallies and the count, so every result is due before it is sampled. The latency check measures the exact cycle distance to the press pulse and tests it against both bounds.

// File: rtl/btn_press_counter.sv
module btn_press_counter #(
  parameter int TICK_DIV = 50_000_000,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_i,
  output logic             press_o,
  output logic             release_o,
  output logic [CNT_W-1:0] count_o
);

  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_DIV - 1);

  logic [1:0]    sync_q;
  logic [TW-1:0] tick_cnt;
  logic          samp_q;
  logic          level_q;

  wire tick   = (tick_cnt == TICK_LAST);
  wire stable = sync_q[1];
  wire accept = tick && (stable == samp_q) && (stable != level_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '0;
      tick_cnt  <= '0;
      samp_q    <= 1'b0;
      level_q   <= 1'b0;
      press_o   <= 1'b0;
      release_o <= 1'b0;
      count_o   <= '0;
    end else begin
      sync_q    <= {sync_q[0], btn_i};
      tick_cnt  <= tick ? '0 : tick_cnt + TW'(1);
      if (tick)   samp_q  <= stable;
      if (accept) level_q <= stable;
      press_o   <= accept && stable;
      release_o <= accept && !stable;
      if (press_o) count_o <= count_o + CNT_W'(1);
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (count_o == '0 && !press_o && !release_o));

  // R2
  press_width_chk: assert property (@(posedge clk) disable iff (rst)
    press_o |=> !press_o);

  // R3
  release_width_chk: assert property (@(posedge clk) disable iff (rst)
    release_o |=> !release_o);

  // R3
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(press_o && release_o));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    press_o |=> count_o == $past(count_o) + CNT_W'(1));

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !press_o |=> $stable(count_o));

  // R5
  level_from_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |-> $past(tick));

endmodule

// File: tb/btn_press_counter_tb.sv
module btn_press_counter_tb;
  localparam int DIV   = 50;
  localparam int CW    = 4;
  localparam int SETTLE = 4 * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic press, rel;
  logic [CW-1:0] count;

  int checks = 0;
  int errors = 0;
  int n_press = 0;
  int n_rel = 0;
  int wide_err = 0;
  logic prev_p = 1'b0, prev_r = 1'b0;

  always #4 clk = ~clk;

  btn_press_counter #(.TICK_DIV(DIV), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .btn_i(btn),
    .press_o(press), .release_o(rel), .count_o(count)
  );

  always @(negedge clk) begin
    if (press) n_press++;
    if (rel) n_rel++;
    if ((press && prev_p) || (rel && prev_r)) wide_err++;
    prev_p = press;
    prev_r = rel;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1; btn = 1'b0;
    wait_cyc(5);
    check(count == 0, "R1 count in reset", int'(count), 0);
    check(!press && !rel, "R1 pulses in reset", int'({press, rel}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(count == 0 && !press && !rel, "R1 first cycle after reset", int'(count), 0);
  endtask

  task automatic t_clean_press;
    int p0, r0, lat;
    logic [CW-1:0] c0;
    p0 = n_press; r0 = n_rel; c0 = count; lat = 0;
    @(negedge clk); btn = 1'b1;
    while (!press && lat < 4 * DIV) begin @(negedge clk); lat++; end
    check(lat >= DIV + 1 && lat <= 2 * DIV + 4, "R8 press latency", lat, 2 * DIV);
    wait_cyc(SETTLE);
    check(n_press - p0 == 1, "R2 one press pulse", n_press - p0, 1);
    check(n_rel == r0, "R2 no release while held", n_rel - r0, 0);
    check(count == c0 + CW'(1), "R6 count +1", int'(count), int'(c0 + CW'(1)));
  endtask

  task automatic t_clean_release;
    int r0;
    logic [CW-1:0] c0;
    r0 = n_rel; c0 = count;
    @(negedge clk); btn = 1'b0;
    wait_cyc(SETTLE);
    check(n_rel - r0 == 1, "R3 one release pulse", n_rel - r0, 1);
    check(count == c0, "R3 count unchanged", int'(count), int'(c0));
  endtask

  task automatic t_bounce;
    int p0;
    logic [CW-1:0] c0;
    p0 = n_press; c0 = count;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); btn = ((i * 7) % 5) > 1;
    end
    @(negedge clk); btn = 1'b1;
    wait_cyc(SETTLE);
    check(n_press - p0 == 1, "R4 bounce gives one press", n_press - p0, 1);
    check(count == c0 + CW'(1), "R4 count +1 after bounce", int'(count), int'(c0 + CW'(1)));
    t_clean_release();
  endtask

  task automatic t_glitch;
    int p0, r0;
    logic [CW-1:0] c0;
    p0 = n_press; r0 = n_rel; c0 = count;
    @(negedge clk); btn = 1'b1;
    wait_cyc(3);
    btn = 1'b0;
    wait_cyc(SETTLE);
    check(n_press == p0, "R5 high glitch ignored", n_press - p0, 0);
    check(count == c0, "R5 count unchanged by glitch", int'(count), int'(c0));
    t_clean_press();
    r0 = n_rel;
    @(negedge clk); btn = 1'b0;
    wait_cyc(3);
    btn = 1'b1;
    wait_cyc(SETTLE);
    check(n_rel == r0, "R5 low glitch ignored", n_rel - r0, 0);
    t_clean_release();
  endtask

  task automatic t_wrap;
    while (count != CW'(15)) begin
      t_clean_press();
      t_clean_release();
    end
    check(count == 15, "R7 reached top", int'(count), 15);
    t_clean_press();
    check(count == 0, "R7 wrap to zero", int'(count), 0);
    t_clean_release();
  endtask

  task automatic t_reset_held;
    int p0, r0;
    t_clean_press();
    p0 = n_press; r0 = n_rel;
    @(negedge clk); rst = 1'b1; btn = 1'b0;
    wait_cyc(5);
    check(count == 0, "R1 reset clears held count", int'(count), 0);
    rst = 1'b0;
    wait_cyc(SETTLE);
    check(n_rel == r0, "R1 no release after reset", n_rel - r0, 0);
    check(n_press == p0, "R1 no press after reset", n_press - p0, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_clean_press();
        t_clean_release();
        t_bounce();
        t_glitch();
        t_wrap();
        t_reset_held();
        check(wide_err == 0, "R2 R3 pulse width one cycle", wide_err, 0);
      end
      begin
        wait_cyc(150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule